// File: doc/BRIEF.md
# Sequential Signed and Unsigned Divider

This unit computes a 32-bit integer quotient or remainder over many clock cycles. One radix-2 restoring shift-and-subtract core serves all four operations. For signed work it converts both operands to magnitudes before the iterations start, and it restores the correct signs in one final cycle. Signed results follow C semantics: the quotient truncates toward zero and the remainder takes the sign of the dividend.

An instruction pipeline uses the unit as follows. It pulses `start` together with a 2-bit operation code, the dividend and the divisor. It then waits for the one-cycle `done` pulse and writes `result` back in place of the dividend. A zero divisor raises a divide-by-zero flag alongside the result; that flag is for the surrounding exception logic.

Top module: `seq_divider`

## Requirements
- R1: With `op` = 2'b01, `result` is the unsigned quotient `a_in / b_in`. With `op` = 2'b11, it is the unsigned remainder `a_in % b_in`.
- R2: With `op` = 2'b00, `result` is the signed quotient of the two's-complement operands, truncated toward zero.
- R3: With `op` = 2'b10, `result` is the signed remainder. It is zero or has the sign of the dividend, and its magnitude is less than that of the divisor.
- R4: When `b_in` is zero, `div_zero` is 1 with the result. The quotient is then 32'hFFFFFFFF and the remainder equals `a_in` unchanged, for signed and unsigned operations alike. A nonzero divisor returns `div_zero` = 0.
- R5: A signed divide of 32'h80000000 by 32'hFFFFFFFF returns 32'h80000000, and the matching signed remainder is 0.
- R6: `done` is high for exactly one cycle. It is high after the 34th rising edge that follows the edge accepting `start`: one setup cycle, 32 iteration cycles and one sign-fix cycle.
- R7: `busy` goes high on the edge that accepts `start` and stays high until the sign-fix cycle ends. It is low in the cycle where `done` is high.
- R8: A `start` pulse while `busy` is high is ignored. The running operation completes with its original operands and operation code.
- R9: After reset, `busy`, `done`, `div_zero` and `result` are all zero.
- R10: `result` and `div_zero` hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Bit 1: 0 quotient, 1 remainder. Bit 0: 0 signed, 1 unsigned |
| a_in | input | 32 | Dividend |
| b_in | input | 32 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient or remainder |
| div_zero | output | 1 | Divisor of the last operation was zero |

## Verification
The bound checker checks the control timing on every cycle:
- `busy` rises after an accepted start.
- `busy` is low whenever `done` is high.
- `done` never lasts two cycles.
- Exactly 34 busy cycles come before each `done`.
- `result` and `div_zero` never move outside a `done` cycle.

Only the bench scenarios can show the arithmetic. Those scenarios cover:
- quotient and remainder values for all operand sign combinations;
- the zero-divisor and most-negative-by-minus-one cases;
- that a start issued mid-operation leaves the running result untouched.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         div_zero
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN, S_FIX} state_t;

  state_t         state;
  logic [1:0]     op_q;
  logic [W-1:0]   a_q, b_q;
  logic [W-1:0]   dvs, quo, rem;
  logic [CW-1:0]  cnt;

  wire            is_signed = ~op_q[0];
  wire            want_rem  = op_q[1];
  wire            neg_q     = is_signed & (a_q[W-1] ^ b_q[W-1]);
  wire            neg_r     = is_signed & a_q[W-1];
  wire            b_zero    = (b_q == '0);

  wire [W:0]      shifted   = {rem, quo[W-1]};
  wire [W:0]      trial     = shifted - {1'b0, dvs};
  wire            fits      = ~trial[W];

  wire [W-1:0]    q_fix     = neg_q ? -quo : quo;
  wire [W-1:0]    r_fix     = neg_r ? -rem : rem;
  wire [W-1:0]    fin       = b_zero ? (want_rem ? a_q : '1)
                                     : (want_rem ? r_fix : q_fix);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      dvs      <= '0;
      quo      <= '0;
      rem      <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      result   <= '0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          op_q  <= op;
          a_q   <= a_in;
          b_q   <= b_in;
          state <= S_SETUP;
        end
        S_SETUP: begin
          quo   <= (is_signed && a_q[W-1]) ? -a_q : a_q;
          dvs   <= (is_signed && b_q[W-1]) ? -b_q : b_q;
          rem   <= '0;
          cnt   <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          rem <= fits ? trial[W-1:0] : shifted[W-1:0];
          quo <= {quo[W-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) state <= S_FIX;
        end
        S_FIX: begin
          result   <= fin;
          div_zero <= b_zero;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         div_zero
);
  localparam int LAT = W + 2;
  localparam int KW  = $clog2(LAT + 2) + 1;

  logic [KW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == KW'(LAT)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(div_zero)));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .div_zero(div_zero)
);

// File: tb/seq_divider_tb_top.sv
`timescale 1ns/1ps
module seq_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        busy, done, div_zero;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  seq_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in),
    .b_in(b_in), .busy(busy), .done(done), .result(result), .div_zero(div_zero)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b, output logic z);
    logic [31:0] ma, mb, q, r;
    z = (b == 0);
    if (b == 0) return o[1] ? a : 32'hFFFF_FFFF;
    if (o[0]) return o[1] ? (a % b) : (a / b);
    ma = a[31] ? -a : a;
    mb = b[31] ? -b : b;
    q  = ma / mb;
    r  = ma % mb;
    if (a[31] ^ b[31]) q = -q;
    if (a[31]) r = -r;
    return o[1] ? r : q;
  endfunction

  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                     input bit poke, input string tag);
    logic        ez;
    logic [31:0] e;
    int          n;
    e = model(o, a, b, ez);
    @(negedge clk);
    check("R7 idle before start", {31'd0, busy}, 32'd0);
    op = o; a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 5) begin
        op = ~o; a_in = ~a; b_in = b + 32'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done || n > 60) break;
      if (!busy) begin
        n_chk++; n_fail++;
        $display("FAIL R7 busy dropped early actual=0 expected=1");
        break;
      end
    end
    start = 1'b0;
    check({"R6 latency ", tag}, n, 34);
    check({"R7 busy low at done ", tag}, {31'd0, busy}, 32'd0);
    check({tag, " result"}, result, e);
    check({"R4 div_zero flag ", tag}, {31'd0, div_zero}, {31'd0, ez});
    @(negedge clk);
    check({"R6 done single pulse ", tag}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd2024));
    #1;
    check("R9 reset busy", {31'd0, busy}, 32'd0);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R9 reset result", result, 32'd0);
    check("R9 reset div_zero", {31'd0, div_zero}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    run(2'b01, 32'd100, 32'd7, 0, "R1 udiv");
    run(2'b11, 32'd100, 32'd7, 0, "R1 umod");
    run(2'b01, 32'hFFFF_FFFF, 32'd1, 0, "R1 udiv max");
    run(2'b00, -32'sd7, 32'd2, 0, "R2 sdiv neg/pos");
    run(2'b00, 32'd7, -32'sd2, 0, "R2 sdiv pos/neg");
    run(2'b00, -32'sd7, -32'sd2, 0, "R2 sdiv neg/neg");
    run(2'b10, -32'sd7, 32'd2, 0, "R3 smod neg/pos");
    run(2'b10, 32'd7, -32'sd2, 0, "R3 smod pos/neg");
    run(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 overflow quotient");
    run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 overflow remainder");
    run(2'b00, -32'sd9, 32'd0, 0, "R4 sdiv by zero");
    run(2'b11, 32'h1234_5678, 32'd0, 0, "R4 umod by zero");
    run(2'b10, 32'h8765_4321, 32'd0, 0, "R4 smod by zero");
    run(2'b01, 32'd55, 32'd5, 0, "R4 flag clears");
    run(2'b00, 32'd1000, 32'd33, 1, "R8 start while busy");

    keep = result;
    repeat (10) @(negedge clk);
    check("R10 result held", result, keep);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 3 == 0) rb = rb >> ($urandom() % 32);
      if (i % 17 == 0) rb = 32'd0;
      run(2'($urandom() % 4), ra, rb, (i % 9 == 0), "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule